// File: doc/BRIEF.md
# SDR SDRAM Power-Up Initialization Sequencer

This block brings one or two ranks of single-data-rate SDRAM out of power-up. After a start pulse it holds the command bus in NOP for a settling window whose length is computed from the clock frequency. It then runs a fixed command program on each rank in turn: precharge all banks, eight auto-refresh commands, and a mode-register load.

Once the last rank is configured, the sequencer parks the bus in command-inhibit. It then raises a ready flag and a refresh-enable flag, so the memory controller and the periodic refresh scheduler can take over.

The rank count and the CAS latency are sampled when start is accepted. The recovery gaps come from a timing profile chosen by parameter. The fast profile uses 3 clocks after a precharge and 7 after a refresh. The pessimistic profile uses 8 and 16.

Top module: `sdram_init_seq`

## Requirements
- R1: Out of reset, and until start is seen, ready and refresh_en are 0, every chip select is high (command inhibit), ras_n/cas_n/we_n are high and the address is 0.
- R2: The cycle after start is sampled begins a window of CLK_MHZ*WAIT_US cycles. In that window every chip select is low and ras_n/cas_n/we_n are high (NOP).
- R3: After the window, a one-cycle precharge-all goes to rank 0: ras_n=0, cas_n=1, we_n=0, addr bit 10 set, all other address and bank bits 0, and only that rank's select low. It is followed by tRP cycles of NOP on the same select, where tRP is 3 in the fast profile and 8 in the pessimistic one.
- R4: Eight auto-refresh commands follow (ras_n=0, cas_n=0, we_n=1). Each is followed by tRFC NOP cycles, where tRFC is 7 in the fast profile and 16 in the pessimistic one.
- R5: A mode-register load then follows (ras_n=cas_n=we_n=0, bank 0). Its address bits [2:0]=010 select burst length 4, bit 3=0 selects sequential bursts, bits [6:4] carry the CAS latency, and every higher bit is 0. It is followed by 2 NOP cycles.
- R6: A cas_lat input of 2 or 3 is written as is. A value of 0 or 1 is raised to 2.
- R7: With two_ranks=1, the whole precharge/refresh/mode program repeats on chip select 1 immediately after rank 0 finishes. With two_ranks=0, chip select 1 is never driven low after the settling window.
- R8: The cycle after the last trailing NOP, ready and refresh_en both become 1, all selects return high, and this state holds until reset.
- R9: A start pulse while the sequence runs or after it completes has no effect. Changing two_ranks or cas_lat after start is accepted has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the power-up program when idle |
| two_ranks | input | 1 | 1 when a second rank is fitted |
| cas_lat | input | 2 | Requested CAS latency |
| cs_n | output | MAX_RANKS | Active-low chip select per rank |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Address bus |
| ready | output | 1 | Initialization complete |
| refresh_en | output | 1 | Periodic refresh may run |

## Verification
The bound checker checks the following every cycle:
- a command never reaches more than one rank;
- a precharge always carries bit 10;
- a refresh is always followed by NOP;
- a mode word always has legal burst and latency fields;
- ready never falls and coincides with command inhibit.

Some properties can only be shown by the scenarios:
- the exact length of the settling window and of every recovery gap;
- the count of eight refreshes;
- the clamping of low latencies;
- the second-rank repeat;
- the immunity to late start pulses and late input changes.

The scenarios show these by comparing every cycle of the bus against a predicted stream, for both timing profiles at once.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT,
      ST_PRE,
      ST_PRE_GAP,
      ST_REF,
      ST_REF_GAP,
      ST_MRS,
      ST_MRS_GAP,
      ST_DONE
   } seq_state_e;

   typedef enum logic [2:0] {
      CMD_INHIBIT,
      CMD_NOP_ALL,
      CMD_NOP,
      CMD_PREA,
      CMD_REF,
      CMD_MRS
   } sdr_cmd_e;

   localparam logic [2:0] BURST_LEN_4 = 3'b010;

   // latencies below 2 are not trusted and raised to 2
   function automatic logic [2:0] clamp_cl(input logic [1:0] raw);
      return (raw < 2'd2) ? 3'd2 : {1'b0, raw};
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_mode.sv
module sdram_init_mode
   import sdram_init_pkg::*;
#(
   parameter int unsigned ROW_W = 13
) (
   input  logic [1:0]       cl_raw,
   output logic [ROW_W-1:0] mode_word
);

   always_comb begin
      mode_word      = '0;
      mode_word[2:0] = BURST_LEN_4;
      mode_word[3]   = 1'b0;              // sequential burst order
      mode_word[6:4] = clamp_cl(cl_raw);
   end

endmodule

// File: rtl/sdram_init_enc.sv
module sdram_init_enc
   import sdram_init_pkg::*;
#(
   parameter int unsigned ROW_W     = 13,
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned MAX_RANKS = 2,
   parameter int unsigned RANK_W    = 1
) (
   input  sdr_cmd_e             cmd,
   input  logic [RANK_W-1:0]    rank,
   input  logic [ROW_W-1:0]     mode_word,
   output logic [MAX_RANKS-1:0] cs_n,
   output logic                 ras_n,
   output logic                 cas_n,
   output logic                 we_n,
   output logic [BANK_W-1:0]    ba,
   output logic [ROW_W-1:0]     addr
);

   logic targeted;
   assign targeted = (cmd == CMD_NOP) || (cmd == CMD_PREA) ||
                     (cmd == CMD_REF) || (cmd == CMD_MRS);

   generate
      for (genvar r = 0; r < MAX_RANKS; r++) begin : g_sel
         assign cs_n[r] = !((cmd == CMD_NOP_ALL) ||
                            (targeted && (rank == RANK_W'(r))));
      end
   endgenerate

   always_comb begin
      ras_n = 1'b1;
      cas_n = 1'b1;
      we_n  = 1'b1;
      ba    = '0;
      addr  = '0;
      case (cmd)
         CMD_PREA: begin
            ras_n    = 1'b0;
            we_n     = 1'b0;
            addr[10] = 1'b1;
         end
         CMD_REF: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
         end
         CMD_MRS: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
            we_n  = 1'b0;
            addr  = mode_word;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned CLK_MHZ     = 100,
   parameter int unsigned WAIT_US     = 100,
   parameter int unsigned ROW_W       = 13,
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned MAX_RANKS   = 2,
   parameter bit          PESSIMISTIC = 1'b0,
   parameter int unsigned REF_COUNT   = 8,
   parameter int unsigned MRS_TAIL    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 two_ranks,
   input  logic [1:0]           cas_lat,
   output logic [MAX_RANKS-1:0] cs_n,
   output logic                 ras_n,
   output logic                 cas_n,
   output logic                 we_n,
   output logic [BANK_W-1:0]    ba,
   output logic [ROW_W-1:0]     addr,
   output logic                 ready,
   output logic                 refresh_en
);

   localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
   localparam int unsigned RANK_W   = $clog2(MAX_RANKS);
   localparam int unsigned REF_W    = $clog2(REF_COUNT + 1);
   localparam int unsigned CNT_W    = $clog2(WAIT_CYC + 32);

   // recovery gaps of the chosen timing profile
   localparam int unsigned T_RP  = PESSIMISTIC ? 8  : 3;
   localparam int unsigned T_RFC = PESSIMISTIC ? 16 : 7;

   generate
      if (ROW_W < 11) begin : g_bad_row
         $error("ROW_W must reach address bit 10");
      end
      if (MAX_RANKS < 2) begin : g_bad_ranks
         $error("MAX_RANKS must be at least 2");
      end
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("settling window must be at least one cycle");
      end
      if (MRS_TAIL < 1 || REF_COUNT < 2) begin : g_bad_prog
         $error("mode tail and refresh count out of range");
      end
   endgenerate

   seq_state_e          state_q, state_d;
   logic [RANK_W-1:0]   rank_q;
   logic [REF_W-1:0]    ref_cnt_q;
   logic                two_q;
   logic [1:0]          cl_q;
   logic                tmr_load;
   logic [CNT_W-1:0]    tmr_val;
   logic                tmr_expired;
   logic [RANK_W-1:0]   last_rank;
   sdr_cmd_e            cmd;
   logic [ROW_W-1:0]    mode_word;

   assign last_rank = two_q ? RANK_W'(1) : RANK_W'(0);

   sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_IDLE: if (start) begin
            state_d  = ST_WAIT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WAIT_CYC - 1);
         end
         ST_WAIT: if (tmr_expired) state_d = ST_PRE;
         ST_PRE: begin
            state_d  = ST_PRE_GAP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RP - 1);
         end
         ST_PRE_GAP: if (tmr_expired) state_d = ST_REF;
         ST_REF: begin
            state_d  = ST_REF_GAP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RFC - 1);
         end
         ST_REF_GAP: if (tmr_expired)
            state_d = (ref_cnt_q == REF_W'(REF_COUNT)) ? ST_MRS : ST_REF;
         ST_MRS: begin
            state_d  = ST_MRS_GAP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(MRS_TAIL - 1);
         end
         ST_MRS_GAP: if (tmr_expired)
            state_d = (rank_q == last_rank) ? ST_DONE : ST_PRE;
         ST_DONE: state_d = ST_DONE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rank_q    <= '0;
         ref_cnt_q <= '0;
         two_q     <= 1'b0;
         cl_q      <= 2'd0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start) begin
            two_q  <= two_ranks;
            cl_q   <= cas_lat;
            rank_q <= '0;
         end
         if (state_q == ST_PRE)
            ref_cnt_q <= '0;
         if (state_q == ST_REF)
            ref_cnt_q <= ref_cnt_q + 1'b1;
         if (state_q == ST_MRS_GAP && tmr_expired && rank_q != last_rank)
            rank_q <= rank_q + 1'b1;
      end
   end

   always_comb begin
      case (state_q)
         ST_WAIT:                          cmd = CMD_NOP_ALL;
         ST_PRE:                           cmd = CMD_PREA;
         ST_REF:                           cmd = CMD_REF;
         ST_MRS:                           cmd = CMD_MRS;
         ST_PRE_GAP, ST_REF_GAP, ST_MRS_GAP: cmd = CMD_NOP;
         default:                          cmd = CMD_INHIBIT;
      endcase
   end

   sdram_init_mode #(.ROW_W(ROW_W)) u_mode (
      .cl_raw    (cl_q),
      .mode_word (mode_word)
   );

   sdram_init_enc #(
      .ROW_W     (ROW_W),
      .BANK_W    (BANK_W),
      .MAX_RANKS (MAX_RANKS),
      .RANK_W    (RANK_W)
   ) u_enc (
      .cmd       (cmd),
      .rank      (rank_q),
      .mode_word (mode_word),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .ba        (ba),
      .addr      (addr)
   );

   assign ready      = (state_q == ST_DONE);
   assign refresh_en = (state_q == ST_DONE);

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
   parameter int unsigned ROW_W     = 13,
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned MAX_RANKS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [MAX_RANKS-1:0] cs_n,
   input logic                 ras_n,
   input logic                 cas_n,
   input logic                 we_n,
   input logic [BANK_W-1:0]    ba,
   input logic [ROW_W-1:0]     addr,
   input logic                 ready,
   input logic                 refresh_en
);

   logic any_sel, is_nop, is_prea, is_ref, is_mrs, strobes_idle;
   assign any_sel      = (cs_n != '1);
   assign strobes_idle = ras_n && cas_n && we_n;
   assign is_nop       = any_sel && strobes_idle;
   assign is_prea      = any_sel && !ras_n &&  cas_n && !we_n;
   assign is_ref       = any_sel && !ras_n && !cas_n &&  we_n;
   assign is_mrs       = any_sel && !ras_n && !cas_n && !we_n;

   // R2: several selects low at once only while the bus carries NOP
   a_r2_multi_sel_nop: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(~cs_n) > 1) |-> strobes_idle);

   // R3: a real command reaches exactly one rank
   a_r3_one_rank: assert property (@(posedge clk) disable iff (!rst_n)
      (any_sel && !strobes_idle) |-> ($countones(~cs_n) == 1));

   // R3: precharge always addresses all banks
   a_r3_prea_all: assert property (@(posedge clk) disable iff (!rst_n)
      is_prea |-> (addr[10] && ba == '0));

   // R4: a refresh is always followed by NOP
   a_r4_ref_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |=> is_nop);

   // R5: mode word carries burst 4, sequential, legal latency
   a_r5_mode_fields: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> (addr[2:0] == 3'b010 && !addr[3] &&
                  (addr[6:4] == 3'd2 || addr[6:4] == 3'd3)));

   // R8: ready never drops and comes with refresh enabled and bus inhibited
   a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> (ready && refresh_en));

   a_r8_ready_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (cs_n == '1));

   a_r8_ready_after_nop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(is_nop));

endmodule

bind sdram_init_seq sdram_init_chk #(
   .ROW_W     (ROW_W),
   .BANK_W    (BANK_W),
   .MAX_RANKS (MAX_RANKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .ba         (ba),
   .addr       (addr),
   .ready      (ready),
   .refresh_en (refresh_en)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_MHZ    = 1;
   localparam int WAIT_US    = 100;
   localparam int WAIT_CYC   = CLK_MHZ * WAIT_US;

   typedef struct {
      logic [21:0] v;
      string       req;
   } exp_t;

   exp_t q0[$];
   exp_t q1[$];

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic two_ranks = 1'b0;
   logic [1:0] cas_lat = 2'd0;

   logic [1:0]  cs0, cs1;
   logic        ras0, cas0, we0, ras1, cas1, we1;
   logic [1:0]  ba0, ba1;
   logic [12:0] a0, a1;
   logic        rdy0, rdy1, rf0, rf1;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .PESSIMISTIC(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .two_ranks(two_ranks), .cas_lat(cas_lat),
      .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0), .ba(ba0), .addr(a0),
      .ready(rdy0), .refresh_en(rf0));

   sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .PESSIMISTIC(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start), .two_ranks(two_ranks), .cas_lat(cas_lat),
      .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .ba(ba1), .addr(a1),
      .ready(rdy1), .refresh_en(rf1));

   function automatic logic [21:0] pack(input logic rdy, input logic [1:0] cs,
                                        input logic [2:0] rcw, input logic [12:0] a);
      return {rdy, rdy, cs, rcw, 2'b00, a};
   endfunction

   function automatic logic [21:0] obs0();
      return {rdy0, rf0, cs0, ras0, cas0, we0, ba0, a0};
   endfunction

   function automatic logic [21:0] obs1();
      return {rdy1, rf1, cs1, ras1, cas1, we1, ba1, a1};
   endfunction

   task automatic push(ref exp_t q[$], input logic [21:0] v, input string req, input int n);
      exp_t e;
      e.v = v;
      e.req = req;
      repeat (n) q.push_back(e);
   endtask

   // driver side: predicted bus stream from the requirements
   task automatic build(ref exp_t q[$], input bit pess, input bit two,
                        input logic [2:0] cl, input string mrs_req);
      int rp;
      int rfc;
      logic [1:0] cs;
      string rr;
      rp  = pess ? 8 : 3;
      rfc = pess ? 16 : 7;
      push(q, pack(1'b0, 2'b00, 3'b111, 13'h0), "R2", WAIT_CYC);
      for (int r = 0; r < (two ? 2 : 1); r++) begin
         cs = (r == 0) ? 2'b10 : 2'b01;
         rr = (r == 0) ? "R3" : "R7";
         push(q, pack(1'b0, cs, 3'b010, 13'h400), rr, 1);
         push(q, pack(1'b0, cs, 3'b111, 13'h0), rr, rp);
         for (int k = 0; k < 8; k++) begin
            push(q, pack(1'b0, cs, 3'b001, 13'h0), "R4", 1);
            push(q, pack(1'b0, cs, 3'b111, 13'h0), "R4", rfc);
         end
         push(q, pack(1'b0, cs, 3'b000, {6'b0, cl, 4'b0010}), mrs_req, 1);
         push(q, pack(1'b0, cs, 3'b111, 13'h0), "R5", 2);
      end
      push(q, pack(1'b1, 2'b11, 3'b111, 13'h0), "R8", 6);
   endtask

   task automatic check(input string req, input string who, input logic [21:0] got,
                        input logic [21:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", req, who, got, exp);
      end
   endtask

   task automatic run_case(input bit two, input logic [1:0] cl_in,
                           input logic [2:0] cl_eff, input string mrs_req);
      exp_t e;
      int n;
      int len0;
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "u0 reset", obs0(), pack(1'b0, 2'b11, 3'b111, 13'h0));
      check("R1", "u1 reset", obs1(), pack(1'b0, 2'b11, 3'b111, 13'h0));
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1", "u0 idle", obs0(), pack(1'b0, 2'b11, 3'b111, 13'h0));
      check("R1", "u1 idle", obs1(), pack(1'b0, 2'b11, 3'b111, 13'h0));
      two_ranks = two;
      cas_lat = cl_in;
      build(q0, 1'b0, two, cl_eff, mrs_req);
      build(q1, 1'b1, two, cl_eff, mrs_req);
      len0 = q0.size();
      start = 1'b1;
      n = 0;
      while (q0.size() != 0 || q1.size() != 0) begin
         @(negedge clk);
         n++;
         if (q0.size() != 0) begin
            e = q0.pop_front();
            check(e.req, "u0", obs0(), e.v);
         end
         if (q1.size() != 0) begin
            e = q1.pop_front();
            check(e.req, "u1", obs1(), e.v);
         end
         // R9: late input changes and stray start pulses
         if (n == 1) begin
            start = 1'b0;
            two_ranks = ~two;
            cas_lat = ~cl_in;
         end
         start = (n == 30) || (n == len0 - 3);
      end
      start = 1'b0;
   endtask

   initial begin
      run_case(1'b0, 2'd3, 3'd3, "R5");
      run_case(1'b1, 2'd2, 3'd2, "R7");
      run_case(1'b0, 2'd1, 3'd2, "R6");
      run_case(1'b1, 2'd0, 3'd2, "R6");
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: got hung expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule